// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block sits between software-facing control logic and a CAN protocol engine and owns three transmit mailboxes. Each mailbox stores a 32-bit identifier word, a 4-bit data length code and 64 bits of payload. Software loads an empty mailbox and sets the word's request bit to queue it, or asks for a queued mailbox to be withdrawn. When no attempt is in progress, the scheduler presents the frame that should go out next. The engine starts an attempt with a one-cycle pulse and later reports success, lost arbitration or an error.

The order of transmission is chosen in one of two ways. The first follows identifier value. The second follows the order in which requests arrived. A one-shot setting limits every request to a single attempt. Per-mailbox status shows which mailboxes are empty, the result of each request, which queued mailbox would go out last, and which index software should load next. Serialising bits and arbitrating on the wire are left to the engine.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset every mailbox is empty, all done/ok/alst/err and lowest flags are 0, `eng_valid` is 0 and `free_code` is 0.
- R2: A load to an empty mailbox with data length code ≤ 8 stores the identifier word, code and payload. If bit 0 of `ld_id` (the request bit) is 1, the mailbox becomes non-empty and its done/ok/alst/err flags clear on the next cycle. If that bit is 0, the contents are stored and the mailbox stays empty.
- R3: A load whose data length code is greater than 8 is dropped: the mailbox stays empty and nothing is queued.
- R4: A load to a mailbox that is not empty changes nothing, and the frame offered to the engine keeps its old contents.
- R5: With `cfg_fifo_order`=0 the offered mailbox is the pending one with the smallest `id[31:1]` (standard ID [31:21], extended ID [20:3], IDE bit 2, RTR bit 1). On equal values the lower mailbox number wins.
- R6: With `cfg_fifo_order`=1 the offered mailbox is the pending one whose request arrived first.
- R7: `eng_ok` during an attempt sets done and ok for the mailbox in flight, clears its alst and err, and empties it.
- R8: With `cfg_one_shot`=0, `eng_alst` or `eng_err` during an attempt sets that mailbox's alst or err flag and clears ok. The mailbox stays pending, done stays 0, and it is offered again.
- R9: With `cfg_one_shot`=1, a failed attempt sets done plus alst or err and empties the mailbox.
- R10: An abort of a pending mailbox that is not in flight empties it on the next cycle, sets done and clears ok. An abort of an empty mailbox has no effect.
- R11: An abort of the mailbox in flight, including one arriving in the same cycle as its start pulse, waits for the result. Success ends as in R7. A failure empties the mailbox with done set, even when one-shot is off.
- R12: `mb_lowest` flags the pending mailbox that would be chosen last, and only when two or more are pending. `free_code` is the lowest-numbered empty mailbox. When none is empty, it is the flagged lowest-priority mailbox.
- R13: `eng_valid` is 1 exactly when some mailbox is pending and no attempt is in progress. While it is 1, `eng_start` begins an attempt on `eng_idx`, and `eng_valid` is 0 from the next cycle until a result pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_order | input | 1 | 1: request order, 0: identifier priority |
| cfg_one_shot | input | 1 | 1: one attempt per request |
| ld_valid | input | 1 | Load strobe |
| ld_idx | input | 2 | Mailbox to load |
| ld_id | input | 32 | Identifier word, bit 0 = request |
| ld_dlc | input | 4 | Data length code |
| ld_data | input | 64 | Payload bytes |
| abort_valid | input | 1 | Abort strobe |
| abort_idx | input | 2 | Mailbox to abort |
| eng_start | input | 1 | Engine starts attempt on offered frame |
| eng_ok | input | 1 | Attempt succeeded |
| eng_alst | input | 1 | Attempt lost arbitration |
| eng_err | input | 1 | Attempt hit a bus error |
| eng_valid | output | 1 | A frame is offered |
| eng_idx | output | 2 | Offered mailbox |
| eng_id | output | 32 | Offered identifier word |
| eng_dlc | output | 4 | Offered length code |
| eng_data | output | 64 | Offered payload |
| mb_empty | output | 3 | Per-mailbox empty |
| mb_done | output | 3 | Per-mailbox request completed |
| mb_ok | output | 3 | Per-mailbox success |
| mb_alst | output | 3 | Per-mailbox arbitration lost |
| mb_err | output | 3 | Per-mailbox error |
| mb_lowest | output | 3 | Per-mailbox lowest priority |
| free_code | output | 2 | Suggested mailbox to load |

## Verification
The bench goes after equal identifiers, where a design that compared with the wrong sense would send mailbox 2 before mailbox 0. It also covers request order that contradicts identifier order, where a scheduler that ignored the mode would send the smallest identifier first. An abort landing in the same cycle as the start pulse is driven: a design that treated it as idle would empty a mailbox the engine is still sending, and the later result would be lost. Length codes of 9 to 15 and loads into busy mailboxes are also driven; a design that accepted them would queue a bad frame or change a frame under transmission. Failures with one-shot off and on separate retry from completion.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
    localparam int ID_W    = 32;
    localparam int DLC_W   = 4;
    localparam int DATA_W  = 64;
    localparam int MAX_DLC = 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic              pend;
        logic              done;
        logic              ok;
        logic              alst;
        logic              err;
        logic              abt;
    } slot_t;
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_shot,
    input  logic              load_en,
    input  logic [ID_W-1:0]   load_id,
    input  logic [DLC_W-1:0]  load_dlc,
    input  logic [DATA_W-1:0] load_data,
    input  logic              abort_en,
    input  logic              flying,
    input  logic              res_ok,
    input  logic              res_alst,
    input  logic              res_err,
    output slot_t             st_o,
    output logic              leave_o
);
    slot_t slot_d, slot_q;
    logic  leave_d;

    always_comb begin
        slot_d  = slot_q;
        leave_d = 1'b0;
        if (load_en) begin
            slot_d.id   = load_id;
            slot_d.dlc  = load_dlc;
            slot_d.data = load_data;
            if (load_id[0]) begin
                slot_d.pend = 1'b1;
                slot_d.done = 1'b0;
                slot_d.ok   = 1'b0;
                slot_d.alst = 1'b0;
                slot_d.err  = 1'b0;
                slot_d.abt  = 1'b0;
            end
        end else if (slot_q.pend) begin
            if (abort_en && !flying) begin
                slot_d.pend = 1'b0;
                slot_d.done = 1'b1;
                slot_d.ok   = 1'b0;
                leave_d     = 1'b1;
            end else begin
                if (abort_en) slot_d.abt = 1'b1;
                if (res_ok) begin
                    slot_d.pend = 1'b0;
                    slot_d.done = 1'b1;
                    slot_d.ok   = 1'b1;
                    slot_d.alst = 1'b0;
                    slot_d.err  = 1'b0;
                    slot_d.abt  = 1'b0;
                    leave_d     = 1'b1;
                end else if (res_alst || res_err) begin
                    slot_d.ok   = 1'b0;
                    slot_d.alst = res_alst;
                    slot_d.err  = !res_alst;
                    if (one_shot || slot_q.abt || abort_en) begin
                        slot_d.pend = 1'b0;
                        slot_d.done = 1'b1;
                        slot_d.abt  = 1'b0;
                        leave_d     = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign st_o    = slot_q;
    assign leave_o = leave_d;

    // R4
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.pend |=> (slot_q.id == $past(slot_q.id)));

    // R9
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.pend && (res_alst || res_err) && !res_ok && one_shot)
        |=> (!slot_q.pend && slot_q.done));

    // R8
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.pend && (res_alst || res_err) && !res_ok && !one_shot
         && !slot_q.abt && !abort_en) |=> (slot_q.pend && !slot_q.done));
endmodule

// File: rtl/txmb_order.sv
module txmb_order #(
    parameter int NUM_MB = 3,
    parameter int RANK_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MB-1:0]             pend,
    input  logic [NUM_MB-1:0]             req,
    input  logic [NUM_MB-1:0]             leave,
    output logic [NUM_MB-1:0][RANK_W-1:0] rank_o
);
    localparam int CNT_W = $clog2(NUM_MB + 1);

    typedef struct packed {
        logic [NUM_MB-1:0][RANK_W-1:0] rank;
    } ord_t;

    ord_t ord_d, ord_q;
    logic [CNT_W-1:0] stay;

    always_comb begin
        ord_d = ord_q;
        stay  = '0;
        for (int j = 0; j < NUM_MB; j++)
            if (pend[j] && !leave[j]) stay = stay + CNT_W'(1);
        for (int i = 0; i < NUM_MB; i++) begin
            if (req[i]) begin
                ord_d.rank[i] = RANK_W'(stay);
            end else if (pend[i] && !leave[i]) begin
                for (int j = 0; j < NUM_MB; j++)
                    if (pend[j] && leave[j] && (ord_q.rank[j] < ord_q.rank[i]))
                        ord_d.rank[i] = ord_d.rank[i] - RANK_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ord_q <= '0;
        else        ord_q <= ord_d;
    end

    assign rank_o = ord_q.rank;

    generate
        for (genvar a = 0; a < NUM_MB; a++) begin : g_a
            for (genvar b = a + 1; b < NUM_MB; b++) begin : g_b
                // R6
                rank_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (pend[a] && pend[b]) |-> (ord_q.rank[a] != ord_q.rank[b]));
            end
        end
    endgenerate
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick
    import can_txmb_pkg::*;
#(
    parameter int NUM_MB = 3,
    parameter int RANK_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic                          fifo_mode,
    input  logic [NUM_MB-1:0]             pend,
    input  logic [NUM_MB-1:0][ID_W-1:0]   ids,
    input  logic [NUM_MB-1:0][RANK_W-1:0] rank,
    output logic [IDX_W-1:0]              sel_idx,
    output logic [NUM_MB-1:0]             lowest,
    output logic [IDX_W-1:0]              free_code
);
    localparam int KEY_W = ID_W - 1;
    localparam int CNT_W = $clog2(NUM_MB + 1);

    logic [NUM_MB-1:0][KEY_W-1:0] key;
    logic [IDX_W-1:0] worst;
    logic [CNT_W-1:0] cnt;
    logic found_s, found_w, found_f;

    always_comb begin
        for (int i = 0; i < NUM_MB; i++)
            key[i] = fifo_mode ? KEY_W'(rank[i]) : ids[i][ID_W-1:1];
    end

    always_comb begin
        sel_idx   = '0;
        worst     = '0;
        free_code = '0;
        cnt       = '0;
        found_s   = 1'b0;
        found_w   = 1'b0;
        found_f   = 1'b0;
        lowest    = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i]) begin
                cnt = cnt + CNT_W'(1);
                if (!found_s || (key[i] < key[sel_idx])) begin
                    sel_idx = IDX_W'(i);
                    found_s = 1'b1;
                end
                if (!found_w || !(key[i] < key[worst])) begin
                    worst   = IDX_W'(i);
                    found_w = 1'b1;
                end
            end else if (!found_f) begin
                free_code = IDX_W'(i);
                found_f   = 1'b1;
            end
        end
        if (cnt >= CNT_W'(2)) lowest[worst] = 1'b1;
        if (!found_f) free_code = worst;
    end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
    import can_txmb_pkg::*;
#(
    parameter  int NUM_MB = 3,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fifo_order,
    input  logic              cfg_one_shot,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ID_W-1:0]   ld_id,
    input  logic [DLC_W-1:0]  ld_dlc,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              abort_valid,
    input  logic [IDX_W-1:0]  abort_idx,
    input  logic              eng_start,
    input  logic              eng_ok,
    input  logic              eng_alst,
    input  logic              eng_err,
    output logic              eng_valid,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [ID_W-1:0]   eng_id,
    output logic [DLC_W-1:0]  eng_dlc,
    output logic [DATA_W-1:0] eng_data,
    output logic [NUM_MB-1:0] mb_empty,
    output logic [NUM_MB-1:0] mb_done,
    output logic [NUM_MB-1:0] mb_ok,
    output logic [NUM_MB-1:0] mb_alst,
    output logic [NUM_MB-1:0] mb_err,
    output logic [NUM_MB-1:0] mb_lowest,
    output logic [IDX_W-1:0]  free_code
);
    localparam int RANK_W = IDX_W;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] fly;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    slot_t                         st [NUM_MB];
    logic [NUM_MB-1:0]             pend, leave, req, load_en;
    logic [NUM_MB-1:0][ID_W-1:0]   ids;
    logic [NUM_MB-1:0][RANK_W-1:0] rank;
    logic [IDX_W-1:0]              sel_idx;
    logic                          start, any_res;

    assign start   = eng_start && eng_valid;
    assign any_res = ctl_q.busy && (eng_ok || eng_alst || eng_err);

    generate
        for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
            logic fly_q_i;
            assign fly_q_i    = ctl_q.busy && (ctl_q.fly == IDX_W'(i));
            assign load_en[i] = ld_valid && (ld_idx == IDX_W'(i)) && !st[i].pend
                                && (ld_dlc <= DLC_W'(MAX_DLC));
            assign req[i]     = load_en[i] && ld_id[0];

            txmb_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .one_shot  (cfg_one_shot),
                .load_en   (load_en[i]),
                .load_id   (ld_id),
                .load_dlc  (ld_dlc),
                .load_data (ld_data),
                .abort_en  (abort_valid && (abort_idx == IDX_W'(i))),
                .flying    (fly_q_i || (start && (sel_idx == IDX_W'(i)))),
                .res_ok    (fly_q_i && eng_ok),
                .res_alst  (fly_q_i && eng_alst && !eng_ok),
                .res_err   (fly_q_i && eng_err && !eng_ok && !eng_alst),
                .st_o      (st[i]),
                .leave_o   (leave[i])
            );

            assign pend[i]    = st[i].pend;
            assign ids[i]     = st[i].id;
            assign mb_empty[i] = !st[i].pend;
            assign mb_done[i]  = st[i].done;
            assign mb_ok[i]    = st[i].ok;
            assign mb_alst[i]  = st[i].alst;
            assign mb_err[i]   = st[i].err;
        end
    endgenerate

    txmb_order #(.NUM_MB(NUM_MB), .RANK_W(RANK_W)) u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .req    (req),
        .leave  (leave),
        .rank_o (rank)
    );

    txmb_pick #(.NUM_MB(NUM_MB), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
        .fifo_mode (cfg_fifo_order),
        .pend      (pend),
        .ids       (ids),
        .rank      (rank),
        .sel_idx   (sel_idx),
        .lowest    (mb_lowest),
        .free_code (free_code)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.busy = 1'b1;
            ctl_d.fly  = sel_idx;
        end else if (any_res) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign eng_valid = (|pend) && !ctl_q.busy;
    assign eng_idx   = sel_idx;
    assign eng_id    = {st[sel_idx].id[ID_W-1:1], 1'b1};
    assign eng_dlc   = st[sel_idx].dlc;
    assign eng_data  = st[sel_idx].data;

    // R13
    start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !eng_valid);

    // R5
    sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> pend[eng_idx]);

    // R12
    lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mb_lowest));

    // R12
    free_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&pend) |-> mb_empty[free_code]);

    // R3
    dlc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (ld_dlc > DLC_W'(MAX_DLC)) && mb_empty[ld_idx]) |=> mb_empty[$past(ld_idx)]);

    // R7
    ok_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && eng_ok) |=> (mb_done[$past(ctl_q.fly)] && mb_ok[$past(ctl_q.fly)]
                                    && mb_empty[$past(ctl_q.fly)]));
endmodule

// File: tb/can_txmb_sched_bench.sv
module can_txmb_sched_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cfg_fifo_order = 0, cfg_one_shot = 0;
    logic        ld_valid = 0, abort_valid = 0;
    logic [1:0]  ld_idx = 0, abort_idx = 0;
    logic [31:0] ld_id = 0;
    logic [3:0]  ld_dlc = 0;
    logic [63:0] ld_data = 0;
    logic        eng_start = 0, eng_ok = 0, eng_alst = 0, eng_err = 0;
    logic        eng_valid;
    logic [1:0]  eng_idx, free_code;
    logic [31:0] eng_id;
    logic [3:0]  eng_dlc;
    logic [63:0] eng_data;
    logic [2:0]  mb_empty, mb_done, mb_ok, mb_alst, mb_err, mb_lowest;

    can_txmb_sched u_can_txmb_sched (.*);

    int total = 0, bad = 0;
    logic finished = 0;
    string cur_req = "R1";

    logic        m_pend [3], m_done [3], m_ok [3], m_alst [3], m_err [3], m_abt [3];
    logic [31:0] m_id [3];
    logic [3:0]  m_dlc [3];
    logic [63:0] m_data [3];
    int          m_seq [3];
    int          seq_ctr = 0;
    logic        m_busy = 0;
    int          m_fly = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic m_before(input int a, input int b);
        if (cfg_fifo_order) return m_seq[a] < m_seq[b];
        return (m_id[a][31:1] < m_id[b][31:1]) || ((m_id[a][31:1] == m_id[b][31:1]) && a < b);
    endfunction

    function automatic int m_sel();
        int s = -1;
        for (int i = 0; i < 3; i++)
            if (m_pend[i] && (s < 0 || m_before(i, s))) s = i;
        return (s < 0) ? 0 : s;
    endfunction

    function automatic int m_worst();
        int w = -1;
        for (int i = 0; i < 3; i++)
            if (m_pend[i] && (w < 0 || m_before(w, i))) w = i;
        return (w < 0) ? 0 : w;
    endfunction

    function automatic int m_npend();
        int n = 0;
        for (int i = 0; i < 3; i++) if (m_pend[i]) n++;
        return n;
    endfunction

    function automatic logic m_valid();
        return (m_npend() > 0) && !m_busy;
    endfunction

    task automatic compare_all();
        logic [14:0] es;
        logic [2:0]  el;
        int          ef, s;
        for (int i = 0; i < 3; i++) begin
            es[i]      = !m_pend[i];
            es[3 + i]  = m_done[i];
            es[6 + i]  = m_ok[i];
            es[9 + i]  = m_alst[i];
            es[12 + i] = m_err[i];
        end
        chk(cur_req, "status", {mb_err, mb_alst, mb_ok, mb_done, mb_empty}, es);
        el = 3'b000;
        if (m_npend() >= 2) el[m_worst()] = 1'b1;
        chk(cur_req, "lowest(R12)", mb_lowest, el);
        ef = -1;
        for (int i = 0; i < 3; i++) if (!m_pend[i] && ef < 0) ef = i;
        if (ef < 0) ef = m_worst();
        chk(cur_req, "free_code(R12)", free_code, ef);
        chk(cur_req, "eng_valid(R13)", eng_valid, m_valid());
        if (m_valid()) begin
            s = m_sel();
            chk(cur_req, "eng_idx", eng_idx, s);
            chk(cur_req, "eng_frame", {eng_id, eng_dlc, eng_data[27:0]},
                {m_id[s][31:1], 1'b1, m_dlc[s], m_data[s][27:0]});
        end
    endtask

    task automatic model_update();
        int   s = m_sel();
        logic st = eng_start && m_valid();
        for (int i = 0; i < 3; i++) begin
            logic fq = m_busy && (m_fly == i);
            logic fi = fq || (st && s == i);
            logic rok = fq && eng_ok;
            logic ral = fq && eng_alst && !eng_ok;
            logic rer = fq && eng_err && !eng_ok && !eng_alst;
            if (ld_valid && ld_idx == i && !m_pend[i] && ld_dlc <= 8) begin
                m_id[i] = ld_id; m_dlc[i] = ld_dlc; m_data[i] = ld_data;
                if (ld_id[0]) begin
                    m_pend[i] = 1; m_done[i] = 0; m_ok[i] = 0; m_alst[i] = 0; m_err[i] = 0; m_abt[i] = 0;
                    m_seq[i] = seq_ctr; seq_ctr++;
                end
            end else if (m_pend[i]) begin
                logic ab = abort_valid && abort_idx == i;
                if (ab && !fi) begin
                    m_pend[i] = 0; m_done[i] = 1; m_ok[i] = 0;
                end else begin
                    logic had = m_abt[i];
                    if (ab) m_abt[i] = 1;
                    if (rok) begin
                        m_pend[i] = 0; m_done[i] = 1; m_ok[i] = 1; m_alst[i] = 0; m_err[i] = 0; m_abt[i] = 0;
                    end else if (ral || rer) begin
                        m_ok[i] = 0; m_alst[i] = ral; m_err[i] = rer;
                        if (cfg_one_shot || had || ab) begin
                            m_pend[i] = 0; m_done[i] = 1; m_abt[i] = 0;
                        end
                    end
                end
            end
        end
        if (st) begin m_busy = 1; m_fly = s; end
        else if (m_busy && (eng_ok || eng_alst || eng_err)) m_busy = 0;
    endtask

    task automatic tick();
        compare_all();
        model_update();
        @(posedge clk);
        @(negedge clk);
        ld_valid = 0; abort_valid = 0; eng_start = 0; eng_ok = 0; eng_alst = 0; eng_err = 0;
    endtask

    task automatic load(input int idx, input logic [31:0] id, input logic [3:0] dlc, input logic [63:0] data);
        ld_valid = 1; ld_idx = 2'(idx); ld_id = id; ld_dlc = dlc; ld_data = data;
        tick();
    endtask

    task automatic abort(input int idx);
        abort_valid = 1; abort_idx = 2'(idx);
        tick();
    endtask

    localparam logic [31:0] ID_A = (32'h300 << 21) | 32'h1;
    localparam logic [31:0] ID_B = (32'h100 << 21) | 32'h1;

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_pend[i] = 0; m_done[i] = 0; m_ok[i] = 0; m_alst[i] = 0; m_err[i] = 0; m_abt[i] = 0;
            m_id[i] = 0; m_dlc[i] = 0; m_data[i] = 0; m_seq[i] = 0;
        end
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R1";
        chk("R1", "empty", mb_empty, 3'b111);
        chk("R1", "eng_valid", eng_valid, 1'b0);
        chk("R1", "free_code", free_code, 2'd0);
        tick();

        cur_req = "R5";
        load(2, ID_A, 4'd1, 64'h11);
        load(1, ID_B, 4'd2, 64'h22);
        load(0, ID_B, 4'd3, 64'h33);
        chk("R5", "tie picks lower index", eng_idx, 2'd0);
        chk("R2", "all pending", mb_empty, 3'b000);
        chk("R12", "lowest", mb_lowest, 3'b100);
        chk("R12", "free when full", free_code, 2'd2);

        cur_req = "R4";
        load(0, (32'h7FF << 21) | 32'h1, 4'd2, 64'hDEAD);
        chk("R4", "frame unchanged", {eng_id, eng_dlc}, {ID_B, 4'd3});

        cur_req = "R10";
        abort(0); abort(1); abort(2);
        chk("R10", "empty", mb_empty, 3'b111);
        chk("R10", "done", mb_done, 3'b111);
        chk("R10", "ok", mb_ok, 3'b000);
        abort(1);
        chk("R10", "abort empty no effect", {mb_empty, mb_done}, {3'b111, 3'b111});

        cur_req = "R3";
        load(1, ID_B, 4'd9, 64'h99);
        chk("R3", "long dlc dropped", {mb_empty[1], eng_valid}, {1'b1, 1'b0});

        cur_req = "R2";
        load(1, ID_B & ~32'h1, 4'd4, 64'h44);
        chk("R2", "no request stays empty", mb_empty[1], 1'b1);

        cur_req = "R6";
        cfg_fifo_order = 1;
        load(2, (32'h010 << 21) | 32'h1, 4'd1, 64'h5);
        load(0, (32'h7F0 << 21) | 32'h1, 4'd2, 64'h6);
        load(1, ID_A, 4'd3, 64'h7);
        chk("R6", "oldest first", eng_idx, 2'd2);
        cur_req = "R13";
        eng_start = 1; tick();
        chk("R13", "valid drops", eng_valid, 1'b0);
        cur_req = "R7";
        eng_ok = 1; tick();
        chk("R7", "ok/done/empty", {mb_ok[2], mb_done[2], mb_empty[2]}, 3'b111);
        chk("R6", "next oldest", eng_idx, 2'd0);

        cur_req = "R8";
        eng_start = 1; tick();
        eng_alst = 1; tick();
        chk("R8", "alst kept pending", {mb_alst[0], mb_empty[0], mb_done[0]}, 3'b100);
        chk("R8", "offered again", {eng_valid, eng_idx}, {1'b1, 2'd0});

        cur_req = "R11";
        eng_start = 1; abort_valid = 1; abort_idx = 2'd0; tick();
        chk("R11", "abort in flight waits", mb_empty[0], 1'b0);
        eng_ok = 1; tick();
        chk("R11", "success wins", {mb_ok[0], mb_done[0], mb_empty[0]}, 3'b111);
        eng_start = 1; tick();
        abort(1);
        eng_err = 1; tick();
        chk("R11", "fail ends aborted", {mb_empty[1], mb_done[1], mb_err[1], mb_ok[1]}, 4'b1110);

        cur_req = "R9";
        cfg_one_shot = 1;
        load(0, ID_B, 4'd8, 64'h0102030405060708);
        eng_start = 1; tick();
        eng_err = 1; tick();
        chk("R9", "one shot ends", {mb_empty[0], mb_done[0], mb_err[0]}, 3'b111);

        for (int blk = 0; blk < 4; blk++) begin
            cfg_fifo_order = blk[0];
            cfg_one_shot   = blk[1];
            cur_req = blk[1] ? "R9" : "R8";
            repeat (150) begin
                int r = $urandom_range(99);
                if (r < 35) begin
                    logic [31:0] pick_id;
                    case ($urandom_range(3))
                        0: pick_id = 32'h100 << 21;
                        1: pick_id = 32'h200 << 21;
                        2: pick_id = (32'h100 << 21) | (32'($urandom_range(255)) << 3);
                        default: pick_id = 32'h7FF << 21;
                    endcase
                    ld_valid = 1; ld_idx = 2'($urandom_range(2));
                    ld_id = pick_id | 32'($urandom_range(99) < 85);
                    ld_dlc = ($urandom_range(9) == 0) ? 4'(9 + $urandom_range(6)) : 4'($urandom_range(8));
                    ld_data = {$urandom, $urandom};
                end
                if ($urandom_range(99) < 8) begin
                    abort_valid = 1; abort_idx = 2'($urandom_range(2));
                end
                if (m_busy) begin
                    case ($urandom_range(5))
                        0: eng_ok = 1;
                        1: eng_alst = 1;
                        2: eng_err = 1;
                        3: eng_ok = 1;
                        default: ;
                    endcase
                end else if ($urandom_range(99) < 50) eng_start = 1;
                tick();
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule